// File: doc/BRIEF.md
# Data-Strobe Token Link Receiver

This block is the receive half of a serial link that carries two wires, a data wire and a strobe wire. The two wires never change together, so every change of data XOR strobe marks one transferred bit, and the receiver's own clock only needs to sample both wires a few times per bit. The wires are synchronised, the bit events are recovered, and the bit stream is cut into tokens. Each token starts with a parity bit and a flag bit, followed by either a data byte or a two-bit control code.

Flow-control tokens are not stored. Each one becomes a one-cycle credit pulse to the local transmitter. Data bytes and the two end markers go into an eight-entry buffer that the local port drains. The receiver counts how much buffer space it has already promised the far end. When a whole block of unpromised space is free, it asks the local transmitter to send a flow-control token. A parity failure raises a sticky error flag.

Top module: `ds_link_rx`

## Requirements
- R1: Both wires pass through a two-flop synchroniser. Each change of the synchronised data XOR strobe yields exactly one received bit, whose value is the data wire level. The bit period must be at least three clock cycles.
- R2: A token is the parity bit, then the flag bit, then a payload sent least significant bit first. The payload is 8 data bits when the flag is 0 and 2 control bits when the flag is 1. The first bit after reset starts a token.
- R3: A token passes the parity check when the XOR of the previous token's payload bits, the current flag and the current parity bit is 1. The previous payload counts as all zero for the first token after reset.
- R4: A token that fails the parity check is discarded and sets parity_err, which stays set until reset. The discarded token's payload still feeds the parity check of the next token.
- R5: Control code 0 (binary 00) is a flow-control token. It is never buffered, uses no credit, and produces credit_pulse high for exactly one cycle.
- R6: A data token is buffered with rd_kind 0 and its byte on rd_data. Control code 1 is buffered as rd_kind 1 (end of packet) and control code 2 as rd_kind 2 (end of message), both with rd_data 0. Entries leave in arrival order. rd_valid shows that the head entry is present, and rd_en while rd_valid removes it.
- R7: Control code 3 is discarded without a credit pulse, but it uses one credit.
- R8: The buffer holds eight entries, and its occupancy never exceeds eight.
- R9: fc_request is high exactly when depth minus occupancy minus outstanding credit is at least the block size of 8. fc_grant while fc_request is high adds 8 to the outstanding credit.
- R10: Every parity-correct token other than a flow-control token takes one from the outstanding credit (not below zero). The outstanding credit never exceeds the buffer depth.
- R11: After reset rd_valid, credit_pulse and parity_err are 0 and fc_request is 1.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ds_d | input | 1 | Data wire, asynchronous |
| ds_s | input | 1 | Strobe wire, asynchronous |
| rd_en | input | 1 | Local port removes the head entry |
| rd_valid | output | 1 | Head entry present |
| rd_kind | output | 2 | Head entry kind: 0 data, 1 end of packet, 2 end of message |
| rd_data | output | 8 | Head entry byte |
| credit_pulse | output | 1 | One-cycle pulse per received flow-control token |
| fc_request | output | 1 | Ask the local transmitter to send a flow-control token |
| fc_grant | input | 1 | Local transmitter has sent the requested flow-control token |
| parity_err | output | 1 | Sticky parity failure flag |

## Verification
The bench drives the wires at random bit periods down to the three-cycle minimum. A receiver that missed or doubled bit events would lose token framing, and every later token would come out wrong. Parity chaining is checked on the first token after reset and across a discarded token. A design that reset the chain at the wrong point would flag good tokens or miss a bad one. The bench fills the buffer completely and drains it in random amounts. A design that counted credit wrongly would raise fc_request early or never, and one that buffered flow-control or reserved tokens would show extra entries at rd_valid.

// File: rtl/ds_rx_pkg.sv
package ds_rx_pkg;

  localparam int DATA_BITS = 8;
  localparam int CTRL_BITS = 2;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_EOP  = 2'd1,
    KIND_EOM  = 2'd2
  } tok_kind_e;

  localparam logic [1:0] CODE_FCT = 2'b00;
  localparam logic [1:0] CODE_EOP = 2'b01;
  localparam logic [1:0] CODE_EOM = 2'b10;
  localparam logic [1:0] CODE_RSV = 2'b11;

  typedef struct packed {
    tok_kind_e  kind;
    logic [7:0] data;
  } rx_entry_t;

  // odd parity over previous payload, current flag and parity bit
  function automatic logic parity_ok(input logic prev_acc, input logic flag, input logic par);
    return (prev_acc ^ flag ^ par) == 1'b1;
  endfunction

  // buffer space not yet promised to the far end
  function automatic int unsigned free_unadvertised(input int unsigned depth,
                                                    input int unsigned occ,
                                                    input int unsigned outst);
    if (occ + outst >= depth) return 0;
    return depth - occ - outst;
  endfunction

endpackage

// File: rtl/ds_rx_bitrec.sv
module ds_rx_bitrec #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  input  logic s_in,
  output logic bit_evt,
  output logic bit_val
);
  logic [SYNC_STAGES-1:0] d_sy;
  logic [SYNC_STAGES-1:0] s_sy;
  logic                   x_prev;
  logic                   x_now;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_sy <= '0;
          s_sy <= '0;
        end else begin
          d_sy <= d_in;
          s_sy <= s_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_sy <= '0;
          s_sy <= '0;
        end else begin
          d_sy <= {d_sy[SYNC_STAGES-2:0], d_in};
          s_sy <= {s_sy[SYNC_STAGES-2:0], s_in};
        end
      end
    end
  endgenerate

  assign x_now   = d_sy[SYNC_STAGES-1] ^ s_sy[SYNC_STAGES-1];
  assign bit_evt = x_now != x_prev;
  assign bit_val = d_sy[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) x_prev <= 1'b0;
    else        x_prev <= x_now;
  end

  // R1: with a bit period of at least three cycles, events are never back to back
  evt_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_evt |=> !bit_evt);

endmodule

// File: rtl/ds_rx_deframe.sv
module ds_rx_deframe
  import ds_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_evt,
  input  logic       bit_val,
  output logic       tok_valid,
  output rx_entry_t  tok_entry,
  output logic       fct_pulse,
  output logic       rsv_pulse,
  output logic       parity_err
);
  typedef enum logic [1:0] {ST_PAR, ST_FLAG, ST_PAY} fr_state_e;

  fr_state_e  st;
  logic       par_r;
  logic       flag_r;
  logic       bad_r;
  logic       acc;
  logic [7:0] sh;
  logic [3:0] left;
  logic [7:0] sh_n;
  logic       last_bit;
  logic       flag_bad;

  assign sh_n     = {bit_val, sh[7:1]};
  assign last_bit = bit_evt && (st == ST_PAY) && (left == 4'd1);
  assign flag_bad = bit_evt && (st == ST_FLAG) && !parity_ok(acc, bit_val, par_r);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_PAR;
      par_r  <= 1'b0;
      flag_r <= 1'b0;
      bad_r  <= 1'b0;
      acc    <= 1'b0;
      sh     <= '0;
      left   <= '0;
    end else if (bit_evt) begin
      case (st)
        ST_PAR: begin
          par_r <= bit_val;
          st    <= ST_FLAG;
        end
        ST_FLAG: begin
          flag_r <= bit_val;
          bad_r  <= flag_bad;
          acc    <= 1'b0;
          left   <= bit_val ? 4'(CTRL_BITS) : 4'(DATA_BITS);
          st     <= ST_PAY;
        end
        default: begin
          sh   <= sh_n;
          acc  <= acc ^ bit_val;
          left <= left - 4'd1;
          if (left == 4'd1) st <= ST_PAR;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_valid  <= 1'b0;
      tok_entry  <= '0;
      fct_pulse  <= 1'b0;
      rsv_pulse  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      tok_valid <= 1'b0;
      fct_pulse <= 1'b0;
      rsv_pulse <= 1'b0;
      if (flag_bad) parity_err <= 1'b1;
      if (last_bit && !bad_r) begin
        if (!flag_r) begin
          tok_valid <= 1'b1;
          tok_entry <= '{kind: KIND_DATA, data: sh_n};
        end else begin
          case (sh_n[7:6])
            CODE_FCT: fct_pulse <= 1'b1;
            CODE_EOP: begin
              tok_valid <= 1'b1;
              tok_entry <= '{kind: KIND_EOP, data: 8'h00};
            end
            CODE_EOM: begin
              tok_valid <= 1'b1;
              tok_entry <= '{kind: KIND_EOM, data: 8'h00};
            end
            default:  rsv_pulse <= 1'b1;
          endcase
        end
      end
    end
  end

  // R4
  parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> parity_err);

  // R5
  fct_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fct_pulse |=> !fct_pulse);

endmodule

// File: rtl/ds_rx_fifo.sv
module ds_rx_fifo
  import ds_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  rx_entry_t wr_entry,
  input  logic      rd_en,
  output rx_entry_t rd_entry,
  output logic      rd_valid,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic          push;
  logic          pop;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign rd_valid = count != '0;
  assign push     = wr_en && (count != CW'(DEPTH));
  assign pop      = rd_en && rd_valid;
  assign rd_entry = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wp] <= wr_entry;
        wp      <= wrap_inc(wp);
      end
      if (pop) rp <= wrap_inc(rp);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R8
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6
  push_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_valid) |=> rd_valid);

endmodule

// File: rtl/ds_rx_credit.sv
module ds_rx_credit
  import ds_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BLOCK = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] occ,
  input  logic                       consume,
  input  logic                       fc_grant,
  output logic                       fc_request,
  output logic [$clog2(DEPTH+1)-1:0] outst
);
  localparam int CW = $clog2(DEPTH+1);

  int unsigned nxt;

  assign fc_request = free_unadvertised(DEPTH, 32'(occ), 32'(outst)) >= BLOCK;

  always_comb begin
    nxt = 32'(outst);
    if (fc_grant && fc_request) nxt = nxt + BLOCK;
    if (consume && outst != '0) nxt = nxt - 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else        outst <= CW'(nxt);
  end

  // R10
  outst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= CW'(DEPTH));

  // R9
  grant_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_grant && fc_request && !consume) |=> outst > $past(outst));

endmodule

// File: rtl/ds_link_rx.sv
module ds_link_rx
  import ds_rx_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int BLOCK       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ds_d,
  input  logic       ds_s,
  input  logic       rd_en,
  output logic       rd_valid,
  output logic [1:0] rd_kind,
  output logic [7:0] rd_data,
  output logic       credit_pulse,
  output logic       fc_request,
  input  logic       fc_grant,
  output logic       parity_err
);
  localparam int CW = $clog2(DEPTH+1);

  logic          bit_evt;
  logic          bit_val;
  logic          tok_valid;
  rx_entry_t     tok_entry;
  logic          rsv_pulse;
  rx_entry_t     head;
  logic [CW-1:0] occ;
  logic [CW-1:0] outst;
  logic          consume;

  ds_rx_bitrec #(.SYNC_STAGES(SYNC_STAGES)) u_bitrec (
    .clk(clk), .rst_n(rst_n), .d_in(ds_d), .s_in(ds_s),
    .bit_evt(bit_evt), .bit_val(bit_val)
  );

  ds_rx_deframe u_deframe (
    .clk(clk), .rst_n(rst_n), .bit_evt(bit_evt), .bit_val(bit_val),
    .tok_valid(tok_valid), .tok_entry(tok_entry), .fct_pulse(credit_pulse),
    .rsv_pulse(rsv_pulse), .parity_err(parity_err)
  );

  ds_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(tok_valid), .wr_entry(tok_entry),
    .rd_en(rd_en), .rd_entry(head), .rd_valid(rd_valid), .count(occ)
  );

  assign consume = tok_valid || rsv_pulse;

  ds_rx_credit #(.DEPTH(DEPTH), .BLOCK(BLOCK)) u_credit (
    .clk(clk), .rst_n(rst_n), .occ(occ), .consume(consume),
    .fc_grant(fc_grant), .fc_request(fc_request), .outst(outst)
  );

  assign rd_kind = head.kind;
  assign rd_data = head.data;

endmodule

// File: tb/ds_link_rx_test.sv
module ds_link_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ds_d = 1'b0;
  logic       ds_s = 1'b0;
  logic       rd_en = 1'b0;
  logic       fc_grant = 1'b0;
  logic       rd_valid;
  logic [1:0] rd_kind;
  logic [7:0] rd_data;
  logic       credit_pulse;
  logic       fc_request;
  logic       parity_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  ds_link_rx uut (
    .clk(clk), .rst_n(rst_n), .ds_d(ds_d), .ds_s(ds_s), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_kind(rd_kind), .rd_data(rd_data),
    .credit_pulse(credit_pulse), .fc_request(fc_request),
    .fc_grant(fc_grant), .parity_err(parity_err)
  );

  always #2.5ns clk = ~clk;

  // model state
  logic wire_x = 1'b0;
  logic enc_acc = 1'b0;
  int   occ = 0;
  int   outst = 0;
  int   exp_kind [32];
  int   exp_data [32];
  int   q_head = 0;
  int   q_tail = 0;
  int   pulses_seen = 0;
  int   pulses_exp = 0;
  int   run_len = 0;
  int   max_run = 0;

  always @(posedge clk) begin
    if (rst_n && credit_pulse) begin
      pulses_seen <= pulses_seen + 1;
      run_len <= run_len + 1;
      if (run_len + 1 > max_run) max_run <= run_len + 1;
    end else begin
      run_len <= 0;
    end
  end

  function automatic bit exp_request(input int o, input int c);
    return (8 - o - c) >= 8;
  endfunction

  function automatic logic parity_bit(input logic prev_acc, input logic flag);
    return ~(prev_acc ^ flag);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int per);
    logic nx;
    nx = ~wire_x;
    ds_d = b;
    ds_s = b ^ nx;
    wire_x = nx;
    repeat (per) @(negedge clk);
  endtask

  // flag 0: 8 data bits; flag 1: 2-bit control code in payload[1:0]
  task automatic send_token(input logic flag, input logic [7:0] payload,
                            input bit corrupt, input int per);
    int   n;
    logic p;
    logic a;
    n = flag ? 2 : 8;
    p = parity_bit(enc_acc, flag) ^ logic'(corrupt);
    send_bit(p, per);
    send_bit(flag, per);
    a = 1'b0;
    for (int i = 0; i < n; i++) begin
      send_bit(payload[i], per);
      a = a ^ payload[i];
    end
    enc_acc = a;
    repeat (8) @(negedge clk);
  endtask

  task automatic enqueue(input int k, input int d);
    exp_kind[q_tail % 32] = k;
    exp_data[q_tail % 32] = d;
    q_tail++;
    occ++;
  endtask

  task automatic pop_check(input string req);
    chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
    chk(int'(rd_kind) == exp_kind[q_head % 32] && int'(rd_data) == exp_data[q_head % 32],
        req, int'({rd_kind, rd_data}), exp_kind[q_head % 32] * 256 + exp_data[q_head % 32]);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    q_head++;
    occ--;
  endtask

  task automatic grant();
    chk(fc_request == 1'b1, "R9 request before grant", int'(fc_request), 1);
    fc_grant = 1'b1;
    @(negedge clk);
    fc_grant = 1'b0;
    outst += 8;
    chk(fc_request == 1'b0, "R9 request drops after grant", int'(fc_request), 0);
  endtask

  // kinds: 0 data, 1 eop, 2 eom, 3 fct, 4 reserved
  task automatic send_kind(input int kind, input logic [7:0] d, input int per);
    case (kind)
      0: begin send_token(1'b0, d, 0, per); enqueue(0, int'(d)); outst--; end
      1: begin send_token(1'b1, 8'h01, 0, per); enqueue(1, 0); outst--; end
      2: begin send_token(1'b1, 8'h02, 0, per); enqueue(2, 0); outst--; end
      3: begin send_token(1'b1, 8'h00, 0, per); pulses_exp++; end
      default: begin send_token(1'b1, 8'h03, 0, per); outst--; end
    endcase
    chk(rd_valid == (occ > 0), "R6 rd_valid after token", int'(rd_valid), int'(occ > 0));
    chk(fc_request == exp_request(occ, outst), "R9/R10 fc_request after token",
        int'(fc_request), int'(exp_request(occ, outst)));
    chk(pulses_seen == pulses_exp, "R5 credit pulse count", pulses_seen, pulses_exp);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(rd_valid == 1'b0, "R11 rd_valid at reset", int'(rd_valid), 0);
    chk(credit_pulse == 1'b0, "R11 credit_pulse at reset", int'(credit_pulse), 0);
    chk(parity_err == 1'b0, "R11 parity_err at reset", int'(parity_err), 0);
    chk(fc_request == 1'b1, "R11 fc_request at reset", int'(fc_request), 1);

    // directed: first token after reset checks R3 chaining from zero, full fill R8
    grant();
    for (int i = 0; i < 8; i++) send_kind(0, 8'(8'hA0 + i), 3);
    chk(rd_valid == 1'b1 && occ == 8, "R8 buffer holds eight", int'(rd_valid), 1);
    chk(parity_err == 1'b0, "R3 good parity chain", int'(parity_err), 0);
    send_kind(3, 8'h00, 3);
    chk(fc_request == 1'b0, "R9 no request while full", int'(fc_request), 0);
    while (occ > 0) pop_check("R6 order after full fill");
    chk(fc_request == 1'b1, "R9 request after drain", int'(fc_request), 1);

    // random rounds
    for (int r = 0; r < 30; r++) begin
      int per;
      int n;
      per = 3 + int'($urandom % 4);
      if (fc_request) grant();
      n = 1 + int'($urandom % 9);
      for (int t = 0; t < n; t++) begin
        int sel;
        int kind;
        sel = int'($urandom % 10);
        kind = (sel < 5) ? 0 : (sel == 5) ? 1 : (sel == 6) ? 2 : (sel < 9) ? 3 : 4;
        if (kind != 3 && outst == 0) kind = 3;
        send_kind(kind, 8'($urandom), per);
      end
      begin
        int m;
        m = (r % 3 == 2) ? occ : int'($urandom % (occ + 1));
        for (int k = 0; k < m; k++) pop_check("R2/R6 random data");
      end
      chk(fc_request == exp_request(occ, outst), "R9 request after drain",
          int'(fc_request), int'(exp_request(occ, outst)));
      // R7: reserved token never appears at rd_valid
      chk(rd_valid == (occ > 0), "R7 reserved not buffered", int'(rd_valid), int'(occ > 0));
    end
    while (occ > 0) pop_check("R6 final drain");
    chk(max_run == 1, "R5 pulse width", max_run, 1);

    // parity error: corrupt data token discarded, flag sticky, chaining continues
    if (fc_request) grant();
    send_kind(0, 8'h5C, 4);
    send_token(1'b0, 8'h37, 1, 4);
    chk(parity_err == 1'b1, "R4 parity_err set", int'(parity_err), 1);
    chk(rd_valid == (occ > 0), "R4 bad token discarded", int'(rd_valid), int'(occ > 0));
    send_kind(0, 8'hE1, 4);
    chk(parity_err == 1'b1, "R4 parity_err sticky", int'(parity_err), 1);
    pop_check("R4 good token before error");
    pop_check("R4 token after error chains parity");
    chk(rd_valid == 1'b0, "R4 only good tokens stored", int'(rd_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule